// File: doc/BRIEF.md
# Three-Phase Triangle-Carrier PWM Gate Controller

This block turns three modulation words into six gate enables for a three-phase bridge. A symmetric triangular carrier, stepped by the reference clock, is compared against each phase's level. Each level is the modulation word scaled by a clamped duty command. Every phase drives a complementary upper/lower pair. A fixed dead band, during which both switches are off, comes before either switch turns on. The same reference clock, divided down, provides a charge-pump clock.

Two inputs choose stop, run or brake. A square-wave mode lets the commutation pattern choose the lower switches directly and PWM-chops the chosen upper switches. An overcurrent flag cuts all gates at once and holds them off until the carrier starts its next period. Modulation words and the duty command are sampled only at the carrier's two turning points, so a change in the middle of a slope never cuts a pulse short.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: The carrier starts at 0 after reset, rises by one each cycle to 126, then falls to 1 and returns to 0. The PWM period is therefore 252 clock cycles.
- R2: Whenever an upper or lower enable of a phase turns on, both enables of that phase have been off for at least 4 cycles before it. In steady complementary running, each on-time is the demanded time minus 4 cycles.
- R3: The upper and lower enables of one phase are never high together.
- R4: Phase p takes bits [7p+6:7p] of `mod_word`, with phase 0 in the low bits. Its level is (word × effective duty) >> 7. In run mode the upper switch is demanded while level > carrier and the lower switch otherwise. A full-scale level of 127 (word 127 at duty 128) keeps the upper switch on for the whole period and the lower switch off.
- R5: When `oc_flag` is high in a cycle, every gate enable is low from the next cycle. They stay low until the carrier next returns to 0 (every 252 cycles, counted from reset release), and resume in the cycle after.
- R6: While `start_n` is high, whatever `brake_n` is, all six enables are low. Reset leaves all enables low.
- R7: While `start_n` is low and `brake_n` is low, all upper enables are low and all lower enables are high.
- R8: A duty command below 12 keeps all six enables low in run and square modes. A duty command above 128 acts as 128.
- R9: `mod_word` and `duty_cmd` are sampled only when the carrier reaches 0 or 126. A change made between those points has no effect until the next one.
- R10: `cp_clk` is the clock divided by 16: 8 cycles low after reset, then 8 high, 8 low, and so on.
- R11: When `sq_mode` is high in run mode, phase p's upper enable follows `sq_hi[p]` chopped by a PWM of level (127 × effective duty) >> 7. Its lower enable follows `sq_lo[p]` unless `sq_hi[p]` is set. The dead band of R2 still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_word | input | 21 | Three 7-bit modulation words, phase 0 lowest |
| duty_cmd | input | 8 | Duty command, clamped to 12..128 |
| start_n | input | 1 | Low to run, high for standby |
| brake_n | input | 1 | Low to brake (lower switches on) |
| oc_flag | input | 1 | Overcurrent detected |
| sq_mode | input | 1 | Square-wave commutation mode |
| sq_hi | input | 3 | Upper switches selected by commutation |
| sq_lo | input | 3 | Lower switches selected by commutation |
| gate_hi | output | 3 | Upper gate enables |
| gate_lo | output | 3 | Lower gate enables |
| cp_clk | output | 1 | Charge-pump clock |

## Verification
The mode assertions assume that `start_n` and `brake_n` hold steady for at least two cycles before their effect is checked. The stimulus only changes these inputs on the falling clock edge and then holds them for whole carrier periods. The steady-state pulse-width checks assume that every demanded upper or lower segment is longer than the dead band. The random generator therefore draws again whenever a phase's demanded width would fall between 1 and 7 cycles of either switch. The overcurrent pulse lasts one cycle and is placed at a known carrier position, so that the release cycle can be predicted.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

  typedef enum logic [1:0] {
    DRV_STOP  = 2'd0,
    DRV_RUN   = 2'd1,
    DRV_BRAKE = 2'd2
  } drv_mode_e;

  // Standby dominates; brake applies only when started.
  function automatic drv_mode_e decode_mode(input logic start_n, input logic brake_n);
    if (start_n) return DRV_STOP;
    if (!brake_n) return DRV_BRAKE;
    return DRV_RUN;
  endfunction

endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int HALF = 126,
  localparam int CW = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o,
  output logic          load_o,   // next value is a turning point
  output logic          wrap_o    // next value is 0 (period start)
);

  logic up;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      up    <= 1'b1;
    end else if (up) begin
      if (cnt_o == CW'(HALF)) begin
        up    <= 1'b0;
        cnt_o <= cnt_o - 1'b1;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end else begin
      if (cnt_o == CW'(1)) up <= 1'b1;
      cnt_o <= cnt_o - 1'b1;
    end
  end

  always_comb begin
    wrap_o = !up && (cnt_o == CW'(1));
    load_o = wrap_o || (up && (cnt_o == CW'(HALF - 1)));
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt_o <= CW'(HALF));
  // R1
  zero_rising_chk: assert property (@(posedge clk) disable iff (rst) (cnt_o == '0) |-> up);

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DEAD = 4,
  localparam int GW = $clog2(DEAD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_req,
  input  logic lo_req,
  input  logic kill,
  output logic hi_o,
  output logic lo_o
);

  logic [GW-1:0] gap;
  logic ready, hi_n, lo_n;

  always_comb begin
    ready = (gap == GW'(DEAD));
    hi_n  = !kill && hi_req && !lo_req && !lo_o && (hi_o || ready);
    lo_n  = !kill && lo_req && !hi_req && !hi_o && (lo_o || ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_o <= 1'b0;
      lo_o <= 1'b0;
      gap  <= '0;
    end else begin
      hi_o <= hi_n;
      lo_o <= lo_n;
      if (hi_n || lo_n) gap <= '0;
      else if (!ready)  gap <= gap + 1'b1;
    end
  end

  // Independent count of cycles with both switches off.
  logic [GW-1:0] off_run;
  always_ff @(posedge clk) begin
    if (rst) off_run <= '0;
    else if (hi_o || lo_o) off_run <= '0;
    else if (off_run != GW'(DEAD)) off_run <= off_run + 1'b1;
  end

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(hi_o && lo_o));
  // R2
  hi_gap_chk: assert property (@(posedge clk) disable iff (rst) $rose(hi_o) |-> off_run == GW'(DEAD));
  // R2
  lo_gap_chk: assert property (@(posedge clk) disable iff (rst) $rose(lo_o) |-> off_run == GW'(DEAD));

endmodule

// File: rtl/pwm_cp_div.sv
module pwm_cp_div #(
  parameter int DIV = 16,
  localparam int HW = DIV / 2,
  localparam int DW = (HW > 1) ? $clog2(HW) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic cp_o
);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      cp_o <= 1'b0;
    end else if (cnt == DW'(HW - 1)) begin
      cnt  <= '0;
      cp_o <= !cp_o;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
  import pwm_gate_pkg::*;
#(
  parameter int NPH      = 3,
  parameter int MOD_W    = 7,
  parameter int DUTY_W   = 8,
  parameter int DUTY_MIN = 12,
  parameter int DUTY_MAX = 128,
  parameter int HALF     = 126,
  parameter int DEAD     = 4,
  parameter int CP_DIV   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPH*MOD_W-1:0] mod_word,
  input  logic [DUTY_W-1:0]    duty_cmd,
  input  logic                 start_n,
  input  logic                 brake_n,
  input  logic                 oc_flag,
  input  logic                 sq_mode,
  input  logic [NPH-1:0]       sq_hi,
  input  logic [NPH-1:0]       sq_lo,
  output logic [NPH-1:0]       gate_hi,
  output logic [NPH-1:0]       gate_lo,
  output logic                 cp_clk
);

  localparam int CW   = $clog2(HALF + 1);
  localparam int DSH  = $clog2(DUTY_MAX);
  localparam int PW   = MOD_W + DUTY_W;
  localparam int FULL = (1 << MOD_W) - 1;

  logic [CW-1:0] cnt;
  logic          load, wrap;

  pwm_carrier #(.HALF(HALF)) u_carrier (
    .clk(clk), .rst(rst), .cnt_o(cnt), .load_o(load), .wrap_o(wrap)
  );

  pwm_cp_div #(.DIV(CP_DIV)) u_cp (.clk(clk), .rst(rst), .cp_o(cp_clk));

  // Duty window: below the offset nothing conducts, above the clamp it saturates.
  logic [DUTY_W-1:0] duty_eff, duty_sh;
  always_comb begin
    if (duty_cmd < DUTY_W'(DUTY_MIN))      duty_eff = '0;
    else if (duty_cmd > DUTY_W'(DUTY_MAX)) duty_eff = DUTY_W'(DUTY_MAX);
    else                                   duty_eff = duty_cmd;
  end

  // Shadow registers loaded only at carrier turning points.
  logic [MOD_W-1:0] mod_sh [NPH];
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_sh <= '0;
      for (int p = 0; p < NPH; p++) mod_sh[p] <= '0;
    end else if (load) begin
      duty_sh <= duty_eff;
      for (int p = 0; p < NPH; p++) mod_sh[p] <= mod_word[p*MOD_W +: MOD_W];
    end
  end

  // Overcurrent latch, released at the start of the next carrier period.
  logic oc_lat, kill;
  always_ff @(posedge clk) begin
    if (rst)          oc_lat <= 1'b0;
    else if (oc_flag) oc_lat <= 1'b1;
    else if (wrap)    oc_lat <= 1'b0;
  end
  assign kill = oc_flag || oc_lat;

  drv_mode_e mode;
  assign mode = decode_mode(start_n, brake_n);

  // Square-wave chopping level: full-scale word scaled by duty.
  logic [MOD_W-1:0] sq_level;
  logic             sq_pwm;
  always_comb begin
    logic [PW-1:0] sq_prod;
    sq_prod  = PW'(FULL) * PW'(duty_sh);
    sq_level = MOD_W'(sq_prod >> DSH);
    sq_pwm   = int'(sq_level) > int'(cnt);
  end

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [MOD_W-1:0] level;
    logic             want;
    logic             hi_q, lo_q;

    always_comb begin
      logic [PW-1:0] prod;
      prod  = PW'(mod_sh[p]) * PW'(duty_sh);
      level = MOD_W'(prod >> DSH);
      want  = int'(level) > int'(cnt);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        hi_q <= 1'b0;
        lo_q <= 1'b0;
      end else begin
        unique case (mode)
          DRV_RUN: begin
            if (duty_sh == '0) begin
              hi_q <= 1'b0;
              lo_q <= 1'b0;
            end else if (sq_mode) begin
              hi_q <= sq_hi[p] && sq_pwm;
              lo_q <= sq_lo[p] && !sq_hi[p];
            end else begin
              hi_q <= want;
              lo_q <= !want;
            end
          end
          DRV_BRAKE: begin
            hi_q <= 1'b0;
            lo_q <= 1'b1;
          end
          default: begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
          end
        endcase
      end
    end

    pwm_deadband #(.DEAD(DEAD)) u_db (
      .clk(clk), .rst(rst), .hi_req(hi_q), .lo_req(lo_q), .kill(kill),
      .hi_o(gate_hi[p]), .lo_o(gate_lo[p])
    );
  end

  // R5
  oc_off_chk: assert property (@(posedge clk) disable iff (rst)
    oc_flag |=> (gate_hi == '0 && gate_lo == '0));
  // R6
  stop_off_chk: assert property (@(posedge clk) disable iff (rst)
    (start_n && $past(start_n) && $past(start_n, 2)) |-> (gate_hi == '0 && gate_lo == '0));
  // R7
  brake_hi_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!start_n && !brake_n) && $past(!start_n && !brake_n, 2)) |-> gate_hi == '0);

endmodule

// File: tb/pwm_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwm_gate_ctrl_tb_top;

  localparam int PER = 252;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [20:0] mod_word = '0;
  logic [7:0]  duty_cmd = '0;
  logic        start_n = 1'b1;
  logic        brake_n = 1'b1;
  logic        oc_flag = 1'b0;
  logic        sq_mode = 1'b0;
  logic [2:0]  sq_hi = '0;
  logic [2:0]  sq_lo = '0;
  logic [2:0]  gate_hi, gate_lo;
  logic        cp_clk;

  always #10 clk = ~clk;

  pwm_gate_ctrl dut_i (
    .clk(clk), .rst(rst), .mod_word(mod_word), .duty_cmd(duty_cmd),
    .start_n(start_n), .brake_n(brake_n), .oc_flag(oc_flag),
    .sq_mode(sq_mode), .sq_hi(sq_hi), .sq_lo(sq_lo),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .cp_clk(cp_clk)
  );

  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int n_tests = 0;
  int n_fail  = 0;
  int hcnt[3];
  int lcnt[3];
  int ovl;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lvl(input int m, input int d);
    int de;
    de = (d < 12) ? 0 : ((d > 128) ? 128 : d);
    return (m * de) >> 7;
  endfunction

  // Carrier steps per period with level > carrier.
  function automatic int nw(input int l);
    if (l <= 0) return 0;
    if (l >= 127) return PER;
    return 2 * l - 1;
  endfunction

  function automatic int ehi(input int n);
    if (n == 0 || n == PER) return n;
    return n - 4;
  endfunction

  function automatic int elo(input int n);
    if (n == 0) return PER;
    if (n == PER) return 0;
    return PER - n - 4;
  endfunction

  task automatic measure();
    for (int p = 0; p < 3; p++) begin
      hcnt[p] = 0;
      lcnt[p] = 0;
    end
    ovl = 0;
    repeat (PER) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        hcnt[p] += int'(gate_hi[p]);
        lcnt[p] += int'(gate_lo[p]);
        if (gate_hi[p] && gate_lo[p]) ovl++;
      end
    end
  endtask

  task automatic settle_measure();
    repeat (3 * PER) @(negedge clk);
    measure();
  endtask

  task automatic run_case(input string req, input int m0, input int m1, input int m2, input int d);
    int ms[3];
    ms[0] = m0; ms[1] = m1; ms[2] = m2;
    @(negedge clk);
    mod_word = {7'(m2), 7'(m1), 7'(m0)};
    duty_cmd = 8'(d);
    settle_measure();
    for (int p = 0; p < 3; p++) begin
      int n;
      n = nw(lvl(ms[p], d));
      chk(req, hcnt[p], (d < 12) ? 0 : ehi(n));
      chk(req, lcnt[p], (d < 12) ? 0 : elo(n));
    end
    chk("R3", ovl, 0);
  endtask

  task automatic expect_counts(input string req, input int h0, input int h1, input int h2,
                               input int l0, input int l1, input int l2);
    settle_measure();
    chk(req, hcnt[0], h0); chk(req, hcnt[1], h1); chk(req, hcnt[2], h2);
    chk(req, lcnt[0], l0); chk(req, lcnt[1], l1); chk(req, lcnt[2], l2);
    chk("R3", ovl, 0);
  endtask

  task automatic random_cases();
    for (int i = 0; i < 8; i++) begin
      int m[3];
      int d;
      bit ok;
      do begin
        d = $urandom_range(0, 255);
        ok = 1'b1;
        for (int p = 0; p < 3; p++) m[p] = $urandom_range(0, 127);
        if (d >= 12) begin
          for (int p = 0; p < 3; p++) begin
            int n;
            n = nw(lvl(m[p], d));
            if (!(n == 0 || n == PER || (n >= 8 && n <= 244))) ok = 1'b0;
          end
        end
      end while (!ok);
      run_case("R4 R2 R8 random", m[0], m[1], m[2], d);
    end
  endtask

  task automatic wait_phase(input int ph);
    do @(negedge clk); while ((cyc % PER) != ph);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    // R6 reset state
    chk("R6 reset", int'({gate_hi, gate_lo}), 0);
    chk("R10 reset", int'(cp_clk), 0);
    rst = 1'b0;
    start_n = 1'b0;

    // R10 charge-pump clock
    begin
      int highs, rises;
      logic prev;
      highs = 0; rises = 0; prev = cp_clk;
      repeat (160) begin
        @(negedge clk);
        highs += int'(cp_clk);
        if (cp_clk && !prev) rises++;
        prev = cp_clk;
      end
      chk("R10 high cycles", highs, 80);
      chk("R10 rises", rises, 10);
    end

    // R4 field positions with distinct words; R2 widths
    run_case("R4 R2 fields", 100, 40, 0, 128);
    // R4 full scale
    run_case("R4 full scale", 127, 127, 127, 128);
    // R8 clamp and offset window
    run_case("R8 clamp", 100, 100, 100, 200);
    run_case("R8 below min", 100, 60, 127, 11);
    run_case("R8 at min", 100, 100, 100, 12);
    random_cases();

    // R1 period between upper turn-on edges
    run_case("R4 R2 base", 60, 60, 60, 128);
    begin
      int r1, r2, seen;
      logic prev;
      seen = 0; r1 = 0; r2 = 0; prev = gate_hi[0];
      repeat (600) begin
        @(negedge clk);
        if (gate_hi[0] && !prev) begin
          if (seen == 0) r1 = cyc; else if (seen == 1) r2 = cyc;
          seen++;
        end
        prev = gate_hi[0];
      end
      chk("R1 period", r2 - r1, PER);
    end

    // R9 words sampled only at turning points
    wait_phase(10);
    mod_word = {7'd5, 7'd5, 7'd5};
    wait_phase(40);
    chk("R9 rising slope keeps old level", int'(gate_hi[0]), 1);
    wait_phase(200);
    chk("R9 new level after peak hi", int'(gate_hi[0]), 0);
    chk("R9 new level after peak lo", int'(gate_lo[0]), 1);

    // R5 overcurrent blanking until next period start
    run_case("R4 R2 oc base", 60, 60, 60, 128);
    wait_phase(50);
    oc_flag = 1'b1;
    begin
      int bad, pstart;
      pstart = (cyc / PER + 1) * PER;
      @(negedge clk);
      oc_flag = 1'b0;
      bad = 0;
      while (cyc <= pstart) begin
        if ({gate_hi, gate_lo} != 6'b0) bad++;
        @(negedge clk);
      end
      chk("R5 blanked until period start", bad, 0);
      while (cyc < pstart + 3) @(negedge clk);
      chk("R5 resumes after period start", int'(gate_hi[0]), 1);
    end

    // R11 square mode
    @(negedge clk);
    sq_mode = 1'b1; sq_hi = 3'b001; sq_lo = 3'b010;
    mod_word = '0; duty_cmd = 8'd64;
    expect_counts("R11 square", nw(lvl(127, 64)), 0, 0, 0, PER, 0);
    @(negedge clk);
    duty_cmd = 8'd11;
    expect_counts("R8 R11 square below min", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    sq_mode = 1'b0; sq_hi = '0; sq_lo = '0;
    duty_cmd = 8'd128; mod_word = {7'd60, 7'd60, 7'd60};

    // R7 brake
    @(negedge clk);
    brake_n = 1'b0;
    expect_counts("R7 brake", 0, 0, 0, PER, PER, PER);

    // R6 standby dominates brake, then plain standby
    @(negedge clk);
    start_n = 1'b1;
    expect_counts("R6 standby with brake", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    brake_n = 1'b1;
    expect_counts("R6 standby", 0, 0, 0, 0, 0, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule